// File: doc/BRIEF.md
# Flash Array Program/Erase Unit

This block keeps a small on-chip byte array that behaves like a NOR flash. A byte program can only pull bits from 1 to 0, so the stored value becomes the old byte ANDed with the new one. A build-time option turns this into a plain overwrite, which suits an EEPROM-like part. An erase puts a whole aligned region back to 0xFF. The erase walks the region one byte per clock and holds a busy output high while it does so.

The array is split into `SECTOR_COUNT` sectors of `SECTOR_BYTES` each, and the page size is 256 bytes. Erase lengths are parameters: a small region (nominally 4 KiB), a mid region (nominally 32 KiB), one sector, or the whole array. A write-enable input gates every request. Per-device capability parameters say which of the small and mid erase sizes the part supports. Three one-cycle flags report problems: a request made while writes are disabled, an erase size the part lacks, and a program that tries to raise a bit from 0 to 1. A separate read port returns any byte one clock after its address is presented.

Top module: `flash_pe_unit`

## Requirements
- R1: After reset every byte reads 0xFF, and `busy`, `errProtect`, `warnSize` and `warnRise` are low.
- R2: An accepted program writes `old & progData` when `OVERWRITE`=0, and writes `progData` unchanged when `OVERWRITE`=1. `rdData` shows the byte at `rdAddr` one clock after the address is sampled.
- R3: `warnRise` pulses for one cycle, on the clock after an accepted program, if `progData` has a 1 in a bit position where the old byte has a 0. This holds in both program modes.
- R4: A program accepted while `wrEn` is low pulses `errProtect` for one cycle, and the write is still applied.
- R5: `eraseKind` selects the erase length: 0 is the small region, 1 the mid region, 2 one sector, 3 the whole array. The start address is aligned down to a multiple of the length, and every byte in the region becomes 0xFF.
- R6: An accepted erase with `wrEn` high raises `busy` on the next clock. `busy` then stays high for exactly as many cycles as the region has bytes.
- R7: An erase request while `wrEn` is low pulses `errProtect`, leaves `busy` low and changes no byte.
- R8: An erase of kind 0 when `CAP_SMALL`=0, or of kind 1 when `CAP_MID`=0, pulses `warnSize` for one cycle. The erase still runs if `wrEn` is high.
- R9: While `busy` is high, program and erase requests are ignored. They change no byte and raise no flag.
- R10: If an erase and a program are requested in the same idle cycle, the erase is taken and the program is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; fills the array with 0xFF |
| wrEn | input | 1 | Write enable that gates program and erase |
| progReq | input | 1 | Single-byte program request |
| progAddr | input | AW | Byte address for the program |
| progData | input | 8 | Byte to program |
| eraseReq | input | 1 | Erase request |
| eraseKind | input | 2 | 0 small, 1 mid, 2 sector, 3 whole array |
| eraseAddr | input | AW | Any address inside the region to erase |
| rdAddr | input | AW | Read address |
| rdData | output | 8 | Byte read, one cycle after `rdAddr` |
| busy | output | 1 | High while an erase sweep runs |
| errProtect | output | 1 | One-cycle pulse: request made while `wrEn` was low |
| warnSize | output | 1 | One-cycle pulse: erase size not supported by this part |
| warnRise | output | 1 | One-cycle pulse: program tried to raise a bit from 0 to 1 |

## Verification
A wrong sweep pointer or remaining count shows up on `busy` as a pulse of the wrong length, visible as soon as the erase ends. Once the region is read back, it also shows as bytes left stale or cleared outside the aligned window. A wrong merge in the datapath shows on `rdData` two clocks after the program request. Because the bench keeps its own image of the whole array and reads all of it back after each phase, no stray write can go unseen. Each flag is compared on the clock right after its request, so a pulse that comes late, twice, or on an ignored request is caught at once.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  typedef enum logic [1:0] {
    ER_SMALL  = 2'd0,
    ER_MID    = 2'd1,
    ER_SECTOR = 2'd2,
    ER_WHOLE  = 2'd3
  } eraseKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic progWr;
    logic fillWr;
  } memStrobe_t;
endpackage

// File: rtl/flash_pe_dpath.sv
module flash_pe_dpath
  import flash_pe_pkg::*;
#(
  parameter int ARRAY_BYTES = 512,
  parameter bit OVERWRITE   = 1'b0,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  memStrobe_t    strobe,
  input  logic [AW-1:0] fillAddr,
  input  logic [AW-1:0] progAddr,
  input  logic [7:0]    progData,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          riseHit
);
  logic [7:0] mem [ARRAY_BYTES];
  logic [7:0] oldByte;
  logic [7:0] merged;

  assign oldByte = mem[progAddr];
  assign riseHit = |(progData & ~oldByte);

  generate
    if (OVERWRITE) begin : g_overwrite
      assign merged = progData;
    end else begin : g_andMerge
      assign merged = oldByte & progData;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
      rdData <= 8'hFF;
    end else begin
      if (strobe.fillWr)      mem[fillAddr] <= 8'hFF;
      else if (strobe.progWr) mem[progAddr] <= merged;
      rdData <= mem[rdAddr];
    end
  end
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
  import flash_pe_pkg::*;
#(
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter int SECTOR_BYTES = 128,
  parameter int ARRAY_BYTES  = 512,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic          progReq,
  input  logic          eraseReq,
  input  logic [1:0]    eraseKind,
  input  logic [AW-1:0] eraseAddr,
  input  logic          riseHit,
  output memStrobe_t    strobe,
  output logic [AW-1:0] fillAddr,
  output logic          busy,
  output logic          errProtect,
  output logic          warnSize,
  output logic          warnRise
);
  localparam logic [AW-1:0] SMALL_MASK  = AW'(SMALL_BYTES - 1);
  localparam logic [AW-1:0] MID_MASK    = AW'(MID_BYTES - 1);
  localparam logic [AW-1:0] SECTOR_MASK = AW'(SECTOR_BYTES - 1);
  localparam logic [AW-1:0] WHOLE_MASK  = AW'(ARRAY_BYTES - 1);

  logic          busyQ;
  logic [AW-1:0] sweepAddr;
  logic [AW-1:0] remain;
  logic [AW-1:0] spanMask;
  logic          takeErase;
  logic          takeProg;
  logic          sizeBad;

  always_comb begin
    case (eraseKind_e'(eraseKind))
      ER_SMALL:  spanMask = SMALL_MASK;
      ER_MID:    spanMask = MID_MASK;
      ER_SECTOR: spanMask = SECTOR_MASK;
      default:   spanMask = WHOLE_MASK;
    endcase
  end

  assign takeErase = eraseReq && !busyQ;
  assign takeProg  = progReq && !busyQ && !eraseReq;
  assign sizeBad   = takeErase &&
                     ((eraseKind == ER_SMALL && !CAP_SMALL) ||
                      (eraseKind == ER_MID   && !CAP_MID));

  assign strobe.fillWr = busyQ;
  assign strobe.progWr = takeProg;
  assign fillAddr      = sweepAddr;
  assign busy          = busyQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busyQ      <= 1'b0;
      sweepAddr  <= '0;
      remain     <= '0;
      errProtect <= 1'b0;
      warnSize   <= 1'b0;
      warnRise   <= 1'b0;
    end else begin
      errProtect <= (takeErase || takeProg) && !wrEn;
      warnSize   <= sizeBad;
      warnRise   <= takeProg && riseHit;
      if (busyQ) begin
        sweepAddr <= sweepAddr + 1'b1;
        remain    <= remain - 1'b1;
        if (remain == '0) busyQ <= 1'b0;
      end else if (takeErase && wrEn) begin
        busyQ     <= 1'b1;
        sweepAddr <= eraseAddr & ~spanMask;
        remain    <= spanMask;
      end
    end
  end
endmodule

// File: rtl/flash_pe_unit.sv
module flash_pe_unit
  import flash_pe_pkg::*;
#(
  parameter int SMALL_BYTES  = 16,
  parameter int MID_BYTES    = 64,
  parameter int SECTOR_BYTES = 128,
  parameter int SECTOR_COUNT = 4,
  parameter bit CAP_SMALL    = 1'b1,
  parameter bit CAP_MID      = 1'b0,
  parameter bit OVERWRITE    = 1'b0,
  localparam int ARRAY_BYTES = SECTOR_BYTES * SECTOR_COUNT,
  localparam int AW = $clog2(ARRAY_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wrEn,
  input  logic          progReq,
  input  logic [AW-1:0] progAddr,
  input  logic [7:0]    progData,
  input  logic          eraseReq,
  input  logic [1:0]    eraseKind,
  input  logic [AW-1:0] eraseAddr,
  input  logic [AW-1:0] rdAddr,
  output logic [7:0]    rdData,
  output logic          busy,
  output logic          errProtect,
  output logic          warnSize,
  output logic          warnRise
);
  memStrobe_t    strobe;
  logic [AW-1:0] fillAddr;
  logic          riseHit;

  flash_pe_ctrl #(
    .SMALL_BYTES(SMALL_BYTES), .MID_BYTES(MID_BYTES),
    .SECTOR_BYTES(SECTOR_BYTES), .ARRAY_BYTES(ARRAY_BYTES),
    .CAP_SMALL(CAP_SMALL), .CAP_MID(CAP_MID)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .progReq(progReq),
    .eraseReq(eraseReq), .eraseKind(eraseKind), .eraseAddr(eraseAddr),
    .riseHit(riseHit), .strobe(strobe), .fillAddr(fillAddr), .busy(busy),
    .errProtect(errProtect), .warnSize(warnSize), .warnRise(warnRise)
  );

  flash_pe_dpath #(
    .ARRAY_BYTES(ARRAY_BYTES), .OVERWRITE(OVERWRITE)
  ) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .fillAddr(fillAddr),
    .progAddr(progAddr), .progData(progData), .rdAddr(rdAddr),
    .rdData(rdData), .riseHit(riseHit)
  );
endmodule

// File: rtl/flash_pe_checker.sv
module flash_pe_checker #(
  parameter int ARRAY_BYTES = 512
) (
  input logic clk,
  input logic rst_n,
  input logic wrEn,
  input logic progReq,
  input logic eraseReq,
  input logic busy,
  input logic errProtect,
  input logic warnSize,
  input logic warnRise
);
  int busyRun;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busyRun <= 0;
    else        busyRun <= busy ? busyRun + 1 : 0;
  end

  // R6: a sweep never lasts longer than the whole array
  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busyRun < ARRAY_BYTES);

  // R6: busy only starts from a write-enabled erase request
  a_r6_busy_origin: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(eraseReq && wrEn));

  // R7: a protected erase never starts a sweep
  a_r7_protect_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (eraseReq && !busy && !wrEn) |=> (!busy && errProtect));

  // R8: size warning only follows an accepted erase request
  a_r8_size_origin: assert property (@(posedge clk) disable iff (!rst_n)
    warnSize |-> $past(eraseReq && !busy));

  // R9: requests during a sweep raise no flag
  a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (progReq || eraseReq)) |=> (!errProtect && !warnSize && !warnRise));

  // R10: a program dropped in favour of an erase raises no rise warning
  a_r10_erase_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (progReq && eraseReq && !busy) |=> !warnRise);
endmodule

bind flash_pe_unit flash_pe_checker #(.ARRAY_BYTES(ARRAY_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .progReq(progReq),
  .eraseReq(eraseReq), .busy(busy), .errProtect(errProtect),
  .warnSize(warnSize), .warnRise(warnRise)
);

// File: tb/flash_pe_unit_bench.sv
module flash_pe_unit_bench;
  localparam int NB = 512;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wrEn = 1'b0, progReq = 1'b0, eraseReq = 1'b0;
  logic [AW-1:0] progAddr = '0, eraseAddr = '0, rdAddr = '0;
  logic [7:0] progData = '0;
  logic [1:0] eraseKind = '0;
  logic [7:0] rdA, rdB;
  logic busyA, busyB, errA, errB, wsA, wsB, wrA, wrB;

  always #5 clk = ~clk;

  // A: AND merge, no mid erase capability. B: overwrite, both capabilities.
  flash_pe_unit u_flash_pe_unit (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .eraseReq(eraseReq), .eraseKind(eraseKind),
    .eraseAddr(eraseAddr), .rdAddr(rdAddr), .rdData(rdA), .busy(busyA),
    .errProtect(errA), .warnSize(wsA), .warnRise(wrA));

  flash_pe_unit #(.CAP_MID(1'b1), .OVERWRITE(1'b1)) u_flash_pe_unit_ovr (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .progReq(progReq), .progAddr(progAddr),
    .progData(progData), .eraseReq(eraseReq), .eraseKind(eraseKind),
    .eraseAddr(eraseAddr), .rdAddr(rdAddr), .rdData(rdB), .busy(busyB),
    .errProtect(errB), .warnSize(wsB), .warnRise(wrB));

  logic [7:0] mA [NB];
  logic [7:0] mB [NB];
  int total = 0, fails = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compareAll(input string req);
    int badA = 0, badB = 0, firstA = -1, firstB = -1;
    for (int a = 0; a < NB; a++) begin
      rdAddr = AW'(a);
      @(negedge clk);
      if (rdA !== mA[a]) begin badA++; if (firstA < 0) firstA = a; end
      if (rdB !== mB[a]) begin badB++; if (firstB < 0) firstB = a; end
    end
    check(badA == 0, {req, " array A mismatches"}, badA, 0);
    check(badB == 0, {req, " array B mismatches"}, badB, 0);
    if (firstA >= 0) check(0, {req, " first bad A byte"}, rdA, mA[firstA]);
    if (firstB >= 0) check(0, {req, " first bad B byte"}, rdB, mB[firstB]);
  endtask

  task automatic prog(input int a, input logic [7:0] d, input bit we);
    bit expRA, expRB;
    expRA = |(d & ~mA[a]);
    expRB = |(d & ~mB[a]);
    mA[a] = mA[a] & d;
    mB[a] = d;
    wrEn = we; progReq = 1'b1; progAddr = AW'(a); progData = d;
    @(negedge clk);
    progReq = 1'b0;
    check(errA == !we && errB == !we, "R4 program errProtect", errA, !we);
    check(wrA == expRA, "R3 warnRise A", wrA, expRA);
    check(wrB == expRB, "R3 warnRise B overwrite", wrB, expRB);
  endtask

  function automatic int spanOf(input int kind);
    case (kind)
      0: return 16;
      1: return 64;
      2: return 128;
      default: return NB;
    endcase
  endfunction

  task automatic erase(input int kind, input int a, input bit we);
    int len, base, nA, nB;
    len = spanOf(kind);
    base = a & ~(len - 1);
    wrEn = we; eraseReq = 1'b1; eraseKind = 2'(kind); eraseAddr = AW'(a);
    @(negedge clk);
    eraseReq = 1'b0;
    check(errA == !we, "R7 erase errProtect", errA, !we);
    check(wsA == (kind == 1), "R8 warnSize A", wsA, kind == 1);
    check(wsB == 1'b0, "R8 warnSize B", wsB, 0);
    nA = 0; nB = 0;
    while (busyA || busyB) begin
      if (busyA) nA++;
      if (busyB) nB++;
      @(negedge clk);
    end
    check(nA == (we ? len : 0), "R6 busy length A", nA, we ? len : 0);
    check(nB == (we ? len : 0), "R6 busy length B", nB, we ? len : 0);
    if (we) for (int i = base; i < base + len; i++) begin mA[i] = 8'hFF; mB[i] = 8'hFF; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) begin mA[i] = 8'hFF; mB[i] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busyA && !errA && !wsA && !wrA, "R1 flags A after reset", {busyA, errA, wsA, wrA}, 0);
    check(!busyB && !errB && !wsB && !wrB, "R1 flags B after reset", {busyB, errB, wsB, wrB}, 0);
    compareAll("R1 power-up 0xFF");

    // R2/R3 first pattern over every byte, then a second merged pattern
    for (int i = 0; i < NB; i++) prog(i, 8'((i * 37 + 11) & 8'hFF), 1'b1);
    compareAll("R2 first program pass");
    for (int i = 0; i < NB; i++) prog(i, 8'(i ^ 8'h5A), 1'b1);
    compareAll("R2 merged program pass");

    // R5/R6/R8: each erase kind, unaligned start addresses
    erase(0, 9'h025, 1'b1);
    compareAll("R5 small erase aligned");
    erase(1, 9'h09A, 1'b1);
    compareAll("R5 R8 mid erase");
    erase(2, 9'h1F0, 1'b1);
    compareAll("R5 sector erase");

    // R7: protected erase leaves storage alone
    erase(2, 9'h010, 1'b0);
    compareAll("R7 protected erase");

    // R4: protected program still applied
    prog(9'h033, 8'h0F, 1'b0);
    prog(9'h034, 8'hF0, 1'b0);
    compareAll("R4 protected program applied");

    // R9: requests during a whole-array sweep are ignored
    wrEn = 1'b1; eraseReq = 1'b1; eraseKind = 2'd3; eraseAddr = 9'h123;
    @(negedge clk);
    check(busyA && busyB, "R6 busy after accept", busyA, 1);
    progReq = 1'b1; progAddr = 9'h005; progData = 8'h00;
    eraseKind = 2'd0; wrEn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!errA && !wsA && !wrA && !errB && !wrB, "R9 flags during busy",
          {errA, wsA, wrA}, 0);
    progReq = 1'b0; eraseReq = 1'b0; wrEn = 1'b1;
    while (busyA || busyB) @(negedge clk);
    for (int i = 0; i < NB; i++) begin mA[i] = 8'hFF; mB[i] = 8'hFF; end
    compareAll("R9 whole erase ignores busy requests");

    // R10: simultaneous erase and program, program dropped
    wrEn = 1'b1; eraseReq = 1'b1; eraseKind = 2'd0; eraseAddr = 9'h040;
    progReq = 1'b1; progAddr = 9'h100; progData = 8'h00;
    @(negedge clk);
    eraseReq = 1'b0; progReq = 1'b0;
    check(!wrA && !wrB, "R10 no rise from dropped program", wrA, 0);
    while (busyA || busyB) @(negedge clk);
    compareAll("R10 program dropped");

    // R2 overwrite mode raises bits back, AND mode cannot
    prog(9'h1AA, 8'h00, 1'b1);
    prog(9'h1AA, 8'hC3, 1'b1);
    rdAddr = 9'h1AA;
    @(negedge clk);
    check(rdA == 8'h00, "R2 AND merge keeps zeros", rdA, 8'h00);
    check(rdB == 8'hC3, "R2 overwrite stores new byte", rdB, 8'hC3);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule